// File: doc/BRIEF.md
# Redundant Clock Failover Policy Controller

This block decides which of two reference clocks, a main source and a backup source, a downstream glitch-free clock multiplexer should pass on. It runs in a free-running system clock domain. For each source it receives three health flags (loss of signal, loss of lock, frequency inside its window) together with a strobe that marks the end of each observation window. A debounce stage turns these noisy per-window observations into a stable GOOD or BAD state for each source.

A policy stage then drives the select output. Leaving a faulty active source is fast. Returning to main in revertive mode needs main to stay GOOD for a soak period. Every change of selection starts a hold-off period, during which no automatic change is made and bad observations are not counted. A parallel override input can force either source. Saturating counters record switches, fault-driven failovers and fault declarations. A flag reports when both sources are BAD.

There is no data stream through this block, so every pin is a plain level or a strobe and none of them uses a handshake. All configuration inputs are static parallel ports.

Top module: `clk_failover_ctrl`

## Requirements
- R1: After reset, `sel_backup` is 0 (main), `sw_req` is 0 and all three counters are 0. Both sources start unqualified (BAD), so `both_bad` is 1.
- R2: A window is a cycle with `win_tick` high, and a window is bad when LOS is 1, LOL is 1 or freq_ok is 0. A GOOD source becomes BAD after `n_bad` consecutive counted bad windows. A BAD source becomes GOOD after `n_good` consecutive good windows. A window of the opposite kind restarts the run.
- R3: With automatic control enabled and no block in force, an active source that is BAD while the other source is GOOD causes a switch to the other source. Each such fault-driven switch adds one to `fail_count`.
- R4: After any change of `sel_backup` at edge E, no automatic change happens at edges E+1 through E+`holdoff_cyc`. Bad windows in that period are not counted.
- R5: With `revertive`=1, the controller returns from backup to main (when not blocked) at the edge after main has been GOOD for `soak_cyc` consecutive cycles. A source becomes GOOD at edge Q, so the return falls at edge Q+`soak_cyc`+1.
- R6: With `revertive`=0, the controller stays on backup while backup is GOOD, even when main is GOOD.
- R7: `ovr_mode`=2'b01 forces main and 2'b10 forces backup at the next edge, whatever the hold-off and health. While either code is applied, no automatic change happens. Codes 2'b00 and 2'b11 select automatic control.
- R8: While both sources are BAD, `both_bad` is 1 and automatic control keeps the current selection.
- R9: After reset, no automatic change happens until main first qualifies GOOD or until `holdoff_cyc` cycles have passed.
- R10: `sw_req` is high for exactly one cycle, in the first cycle that shows a new `sel_backup` value, and is low at every other time.
- R11: `switch_count` counts selection changes. `fail_count` counts fault-driven switches. `alarm_count` counts cycles in which any source is newly declared BAD. Each counter saturates at all-ones. `cnt_clr` clears all three counters at the next edge and takes priority over an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_tick | input | 1 | End-of-observation-window strobe |
| main_los | input | 1 | Main loss of signal |
| main_lol | input | 1 | Main loss of lock |
| main_freq_ok | input | 1 | Main frequency inside window |
| bak_los | input | 1 | Backup loss of signal |
| bak_lol | input | 1 | Backup loss of lock |
| bak_freq_ok | input | 1 | Backup frequency inside window |
| revertive | input | 1 | 1: automatic return to main after soak |
| ovr_mode | input | 2 | 00/11 auto, 01 force main, 10 force backup |
| n_bad | input | CW | Consecutive bad windows needed to declare BAD |
| n_good | input | CW | Consecutive good windows needed to declare GOOD |
| holdoff_cyc | input | TW | Hold-off length in cycles |
| soak_cyc | input | TW | Soak length in cycles |
| cnt_clr | input | 1 | Synchronous counter clear |
| sel_backup | output | 1 | 0 main, 1 backup |
| sw_req | output | 1 | One-cycle strobe on a selection change |
| both_bad | output | 1 | Both sources are BAD |
| switch_count | output | KW | Selection changes (saturating) |
| fail_count | output | KW | Fault-driven switches (saturating) |
| alarm_count | output | KW | BAD declarations (saturating) |

## Verification
The hardest situation to reach is a switch that health alone would demand but that the hold-off must still withhold for an exact number of edges. The stimulus sets the soak length to zero and lets main fail over. It then requalifies main within a few windows, so that only the hold-off holds the return back. The bench checks that the selection is unchanged one edge before the window closes and that the return lands on the first edge after it. Feeding a full run of bad windows into the hold-off that follows the return then shows that these windows produce no declaration, no alarm count and no switch.

// File: rtl/failover_pkg.sv
package failover_pkg;
  typedef enum logic [1:0] {
    OVR_AUTO   = 2'b00,
    OVR_MAIN   = 2'b01,
    OVR_BACKUP = 2'b10,
    OVR_AUTO_B = 2'b11
  } ovr_e;

  localparam int NSRC       = 2;
  localparam int SRC_MAIN   = 0;
  localparam int SRC_BAK    = 1;
  localparam int NCNT       = 3;
  localparam int CNT_SWITCH = 0;
  localparam int CNT_FAIL   = 1;
  localparam int CNT_ALARM  = 2;
endpackage

// File: rtl/src_qualifier.sv
module src_qualifier #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_tick,
  input  logic          obs_bad,
  input  logic          ignore_bad,
  input  logic [CW-1:0] n_bad,
  input  logic [CW-1:0] n_good,
  output logic          good,
  output logic          fault_evt
);
  logic [CW-1:0] run;
  logic [CW:0]   nxt;

  assign nxt = {1'b0, run} + {{CW{1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good      <= 1'b0;
      run       <= '0;
      fault_evt <= 1'b0;
    end else begin
      fault_evt <= 1'b0;
      if (win_tick) begin
        if (good) begin
          if (obs_bad && !ignore_bad) begin
            if (nxt >= {1'b0, n_bad}) begin
              good      <= 1'b0;
              run       <= '0;
              fault_evt <= 1'b1;
            end else begin
              run <= nxt[CW-1:0];
            end
          end else if (!obs_bad) begin
            run <= '0;
          end
        end else begin
          if (!obs_bad) begin
            if (nxt >= {1'b0, n_good}) begin
              good <= 1'b1;
              run  <= '0;
            end else begin
              run <= nxt[CW-1:0];
            end
          end else begin
            run <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/failover_policy.sv
module failover_policy
  import failover_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          main_good,
  input  logic          bak_good,
  input  logic          revertive,
  input  logic [1:0]    ovr_mode,
  input  logic [TW-1:0] holdoff_cyc,
  input  logic [TW-1:0] soak_cyc,
  output logic          sel_backup,
  output logic          sw_req,
  output logic          hold_active,
  output logic          ev_switch,
  output logic          ev_fail
);
  logic [TW-1:0] ho_cnt;
  logic [TW-1:0] st_cnt;
  logic [TW-1:0] soak_cnt;
  logic          start_inh;
  logic          forced;
  logic          auto_ok;
  logic          want_sel;

  assign forced      = (ovr_mode == OVR_MAIN) || (ovr_mode == OVR_BACKUP);
  assign hold_active = (ho_cnt != '0);
  assign auto_ok     = !forced && !hold_active && !start_inh;

  always_comb begin
    want_sel = sel_backup;
    ev_fail  = 1'b0;
    if (ovr_mode == OVR_MAIN) begin
      want_sel = 1'b0;
    end else if (ovr_mode == OVR_BACKUP) begin
      want_sel = 1'b1;
    end else if (auto_ok) begin
      if (!sel_backup) begin
        if (!main_good && bak_good) begin
          want_sel = 1'b1;
          ev_fail  = 1'b1;
        end
      end else if (!bak_good && main_good) begin
        want_sel = 1'b0;
        ev_fail  = 1'b1;
      end else if (revertive && main_good && (soak_cnt >= soak_cyc)) begin
        want_sel = 1'b0;
      end
    end
  end

  assign ev_switch = (want_sel != sel_backup);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_backup <= 1'b0;
      sw_req     <= 1'b0;
      ho_cnt     <= '0;
      st_cnt     <= '0;
      soak_cnt   <= '0;
      start_inh  <= 1'b1;
    end else begin
      sel_backup <= want_sel;
      sw_req     <= ev_switch;
      if (ev_switch) ho_cnt <= holdoff_cyc;
      else if (hold_active) ho_cnt <= ho_cnt - 1'b1;
      if (!main_good) soak_cnt <= '0;
      else if (soak_cnt < soak_cyc) soak_cnt <= soak_cnt + 1'b1;
      if (start_inh) begin
        if (main_good || (st_cnt >= holdoff_cyc)) start_inh <= 1'b0;
        else st_cnt <= st_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (clr) q <= '0;
    else if (inc && !(&q)) q <= q + 1'b1;
  end
endmodule

// File: rtl/clk_failover_ctrl.sv
module clk_failover_ctrl
  import failover_pkg::*;
#(
  parameter int CW = 8,
  parameter int TW = 16,
  parameter int KW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_tick,
  input  logic          main_los,
  input  logic          main_lol,
  input  logic          main_freq_ok,
  input  logic          bak_los,
  input  logic          bak_lol,
  input  logic          bak_freq_ok,
  input  logic          revertive,
  input  logic [1:0]    ovr_mode,
  input  logic [CW-1:0] n_bad,
  input  logic [CW-1:0] n_good,
  input  logic [TW-1:0] holdoff_cyc,
  input  logic [TW-1:0] soak_cyc,
  input  logic          cnt_clr,
  output logic          sel_backup,
  output logic          sw_req,
  output logic          both_bad,
  output logic [KW-1:0] switch_count,
  output logic [KW-1:0] fail_count,
  output logic [KW-1:0] alarm_count
);
  logic [NSRC-1:0] obs_bad;
  logic [NSRC-1:0] src_good;
  logic [NSRC-1:0] src_evt;
  logic            hold_active;
  logic            ev_switch;
  logic            ev_fail;
  logic [NCNT-1:0] cnt_inc;
  logic [KW-1:0]   cnt_val [NCNT];

  assign obs_bad[SRC_MAIN] = main_los | main_lol | ~main_freq_ok;
  assign obs_bad[SRC_BAK]  = bak_los | bak_lol | ~bak_freq_ok;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    src_qualifier #(.CW(CW)) u_qual (
      .clk        (clk),
      .rst_n      (rst_n),
      .win_tick   (win_tick),
      .obs_bad    (obs_bad[g]),
      .ignore_bad (hold_active),
      .n_bad      (n_bad),
      .n_good     (n_good),
      .good       (src_good[g]),
      .fault_evt  (src_evt[g])
    );
  end

  failover_policy #(.TW(TW)) u_policy (
    .clk         (clk),
    .rst_n       (rst_n),
    .main_good   (src_good[SRC_MAIN]),
    .bak_good    (src_good[SRC_BAK]),
    .revertive   (revertive),
    .ovr_mode    (ovr_mode),
    .holdoff_cyc (holdoff_cyc),
    .soak_cyc    (soak_cyc),
    .sel_backup  (sel_backup),
    .sw_req      (sw_req),
    .hold_active (hold_active),
    .ev_switch   (ev_switch),
    .ev_fail     (ev_fail)
  );

  assign both_bad            = ~|src_good;
  assign cnt_inc[CNT_SWITCH] = ev_switch;
  assign cnt_inc[CNT_FAIL]   = ev_fail;
  assign cnt_inc[CNT_ALARM]  = |src_evt;

  for (genvar c = 0; c < NCNT; c++) begin : g_cnt
    sat_counter #(.W(KW)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (cnt_inc[c]),
      .q     (cnt_val[c])
    );
  end

  assign switch_count = cnt_val[CNT_SWITCH];
  assign fail_count   = cnt_val[CNT_FAIL];
  assign alarm_count  = cnt_val[CNT_ALARM];
endmodule

// File: rtl/failover_chk.sv
module failover_chk #(
  parameter int KW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    ovr_mode,
  input logic          cnt_clr,
  input logic          sel_backup,
  input logic          sw_req,
  input logic          both_bad,
  input logic [KW-1:0] switch_count,
  input logic [KW-1:0] fail_count,
  input logic [KW-1:0] alarm_count
);
  // R10
  sw_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req |=> !sw_req);
  // R10
  sel_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_backup != $past(sel_backup)) |-> sw_req);
  // R7
  force_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_mode == 2'b01) |=> !sel_backup);
  // R7
  force_bak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_mode == 2'b10) |=> sel_backup);
  // R8
  both_bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (both_bad && (ovr_mode == 2'b00 || ovr_mode == 2'b11)) |=> $stable(sel_backup));
  // R11
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&switch_count) && !cnt_clr) |=> (&switch_count));
  // R11
  cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (switch_count == '0 && fail_count == '0 && alarm_count == '0));
  // R3
  fail_with_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fail_count != $past(fail_count)) && !$past(cnt_clr)) |-> sw_req);
endmodule

bind clk_failover_ctrl failover_chk #(.KW(KW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ovr_mode     (ovr_mode),
  .cnt_clr      (cnt_clr),
  .sel_backup   (sel_backup),
  .sw_req       (sw_req),
  .both_bad     (both_bad),
  .switch_count (switch_count),
  .fail_count   (fail_count),
  .alarm_count  (alarm_count)
);

// File: tb/sim_clk_failover_ctrl.sv
`timescale 1ns/1ps
module sim_clk_failover_ctrl;
  localparam int CW = 4;
  localparam int TW = 8;
  localparam int KW = 4;
  localparam int HO = 10;
  localparam int SK = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic win_tick = 1'b0;
  logic main_los = 1'b1, main_lol = 1'b0, main_freq_ok = 1'b1;
  logic bak_los = 1'b0, bak_lol = 1'b0, bak_freq_ok = 1'b1;
  logic revertive = 1'b1;
  logic [1:0] ovr_mode = 2'b00;
  logic [CW-1:0] n_bad = 4'd3, n_good = 4'd2;
  logic [TW-1:0] holdoff_cyc = 8'(HO), soak_cyc = 8'(SK);
  logic cnt_clr = 1'b0;
  logic sel_backup, sw_req, both_bad;
  logic [KW-1:0] switch_count, fail_count, alarm_count;

  int cyc = 0;
  int n_chk = 0;
  int n_bad_chk = 0;
  int last_tick = 0;
  int last_sw_cyc = 0;
  int exp_q[$];
  bit mon_on = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clk_failover_ctrl #(.CW(CW), .TW(TW), .KW(KW)) u0 (
    .clk(clk), .rst_n(rst_n), .win_tick(win_tick),
    .main_los(main_los), .main_lol(main_lol), .main_freq_ok(main_freq_ok),
    .bak_los(bak_los), .bak_lol(bak_lol), .bak_freq_ok(bak_freq_ok),
    .revertive(revertive), .ovr_mode(ovr_mode), .n_bad(n_bad), .n_good(n_good),
    .holdoff_cyc(holdoff_cyc), .soak_cyc(soak_cyc), .cnt_clr(cnt_clr),
    .sel_backup(sel_backup), .sw_req(sw_req), .both_bad(both_bad),
    .switch_count(switch_count), .fail_count(fail_count), .alarm_count(alarm_count)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad_chk++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad_chk);
    $finish;
  endtask

  task automatic tick();
    @(negedge clk) win_tick = 1'b1;
    @(posedge clk);
    #1 last_tick = cyc;
    @(negedge clk) win_tick = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic wait_sw();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Scoreboard monitor: each strobe pops the expected new selection
  bit prev_sw = 1'b0;
  bit prev_sel = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (sw_req) begin
        if (prev_sw) check("R10 strobe longer than one cycle", 1, 0);
        if (exp_q.size() == 0) begin
          check("R10 unexpected switch to", int'(sel_backup), int'(prev_sel));
        end else begin
          check("R10 switch target", int'(sel_backup), exp_q.pop_front());
        end
        last_sw_cyc = cyc;
      end else if (sel_backup != prev_sel) begin
        check("R10 select change without strobe", int'(sw_req), 1);
      end
      prev_sw  = sw_req;
      prev_sel = sel_backup;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    int r0, q0, e0, e1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    r0 = cyc;
    mon_on = 1'b1;
    // R1 reset state
    check("R1 sel_backup", int'(sel_backup), 0);
    check("R1 sw_req", int'(sw_req), 0);
    check("R1 switch_count", int'(switch_count), 0);
    check("R1 fail_count", int'(fail_count), 0);
    check("R1 alarm_count", int'(alarm_count), 0);
    check("R1 both_bad", int'(both_bad), 1);

    // R9: backup qualifies, main never does; switching waits for hold-off
    exp_q.push_back(1);
    tick(); tick();
    wait_cyc(r0 + HO - 2);
    check("R9 still main during startup", int'(sel_backup), 0);
    wait_sw();
    check("R3 fail_count after startup failover", int'(fail_count), 1);
    check("R8 both_bad cleared", int'(both_bad), 0);
    repeat (HO + 2) @(negedge clk);

    // R5 revertive return after soak
    main_los = 1'b0;
    tick(); tick();
    q0 = last_tick;
    exp_q.push_back(0);
    wait_cyc(q0 + SK - 1);
    check("R5 no return before soak", int'(sel_backup), 1);
    wait_sw();
    check("R5 return edge", last_sw_cyc, q0 + SK + 1);
    repeat (HO + 2) @(negedge clk);

    // R2 debounce: interrupted run does not declare BAD
    soak_cyc = '0;
    main_lol = 1'b1; tick(); tick();
    main_lol = 1'b0; tick();
    main_lol = 1'b1; tick(); tick();
    repeat (4) @(negedge clk);
    check("R2 interrupted bad run", int'(sel_backup), 0);
    exp_q.push_back(1);
    tick();
    wait_sw();
    e0 = last_sw_cyc;
    check("R2 alarm after full run", int'(alarm_count), 1);

    // R4 hold-off withholds a return that health demands
    main_lol = 1'b0;
    tick(); tick();
    exp_q.push_back(0);
    wait_cyc(e0 + HO - 1);
    check("R4 blocked during hold-off", int'(sel_backup), 1);
    wait_sw();
    check("R4 return edge after hold-off", last_sw_cyc, e0 + HO + 1);

    // R4 bad windows during hold-off are not counted
    e1 = last_sw_cyc;
    main_lol = 1'b1; tick(); tick(); tick();
    main_lol = 1'b0;
    wait_cyc(e1 + 25);
    check("R4 ignored bad windows keep main", int'(sel_backup), 0);
    check("R4 ignored bad windows no alarm", int'(alarm_count), 1);

    // R6 non-revertive stays on backup
    revertive = 1'b0;
    exp_q.push_back(1);
    main_lol = 1'b1; tick(); tick(); tick();
    wait_sw();
    main_lol = 1'b0; tick(); tick();
    repeat (40) @(negedge clk);
    check("R6 stays on backup", int'(sel_backup), 1);
    check("R3 fail_count", int'(fail_count), 3);

    // R8 both sources bad: keep selection
    main_freq_ok = 1'b0; tick(); tick(); tick();
    bak_lol = 1'b1; tick(); tick(); tick();
    repeat (5) @(negedge clk);
    check("R8 both_bad", int'(both_bad), 1);
    check("R8 selection kept", int'(sel_backup), 1);
    check("R10 quiet strobe", int'(sw_req), 0);
    check("R11 alarm_count", int'(alarm_count), 4);

    // R7 overrides
    exp_q.push_back(0);
    ovr_mode = 2'b01;
    wait_sw();
    check("R7 forced main", int'(sel_backup), 0);
    exp_q.push_back(1);
    ovr_mode = 2'b10;
    wait_sw();
    main_freq_ok = 1'b1; tick(); tick();
    repeat (30) @(negedge clk);
    check("R7 override blocks auto", int'(sel_backup), 1);
    exp_q.push_back(0);
    ovr_mode = 2'b00;
    wait_sw();
    check("R3 fault return counted", int'(fail_count), 4);
    check("R11 switch_count", int'(switch_count), 8);

    // R11 saturation and clear
    for (int i = 0; i < 10; i++) begin
      exp_q.push_back(1);
      ovr_mode = 2'b10;
      wait_sw();
      exp_q.push_back(0);
      ovr_mode = 2'b01;
      wait_sw();
    end
    check("R11 switch_count saturates", int'(switch_count), 15);
    ovr_mode = 2'b00;
    @(negedge clk) cnt_clr = 1'b1;
    @(negedge clk) cnt_clr = 1'b0;
    check("R11 clear switch_count", int'(switch_count), 0);
    check("R11 clear fail_count", int'(fail_count), 0);
    check("R11 clear alarm_count", int'(alarm_count), 0);
    repeat (5) @(negedge clk);
    check("R10 no pending switches", exp_q.size(), 0);
    done = 1'b1;
    summary();
  end
endmodule